// File: doc/BRIEF.md
# I/O Port Byte-Lane Steering Unit

This unit connects a processor-side request port for a separate 64K-entry I/O port space to an external bus with two byte lanes. A request names a 16-bit port address, a width (byte or word), a direction and write data. The unit places the bytes on the correct lanes, drives the byte enables and the bus address, and waits for the bus to acknowledge. On reads it returns the data right-justified. Every address selects one 8-bit port, and two neighbouring ports act together as one 16-bit port.

The address parity picks the lane. A byte at an even port uses the lower lane. A byte at an odd port uses the upper lane. A word at an even port moves in one bus cycle on both lanes. A word at an odd port cannot move in one cycle, so the unit splits it into two byte cycles and acknowledges the request only after both have finished. A privilege input refuses the request without any bus activity. Touching the reserved port window 0x00F8 to 0x00FF raises a flag that is returned with the completion.

The requester raises `req_valid` and holds the request fields steady until `done` pulses. The unit accepts the request on a clock edge where `req_valid` and `req_ready` are both high.

Top module: `io_lane_steer`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `bus_cyc` is 0.
- R2: A byte access (`req_word`=0) at an even address runs one bus cycle at that address with `bus_be`=2'b01, where bit 0 enables the lower lane (bits 7:0). Write data goes out on bits 7:0 with bits 15:8 at zero. Read data is taken from bits 7:0 and returned as {8'h00, byte}.
- R3: A byte access at an odd address runs one bus cycle at that address with `bus_be`=2'b10. Write data goes out on bits 15:8 with bits 7:0 at zero. The read byte is taken from bits 15:8, shifted down, and returned in `rdata[7:0]` with the upper bits at zero.
- R4: A word access (`req_word`=1) at an even address runs exactly one bus cycle with `bus_be`=2'b11. It carries all 16 write bits unchanged and returns all 16 read bits unchanged. `bus_be` is never 2'b11 at an odd bus address.
- R5: A word access at odd address A runs two bus cycles. The first is at A with `bus_be`=2'b10 and carries write bits 7:0 on lane bits 15:8. The second is at A+1, taken modulo 65536, with `bus_be`=2'b01 and carries write bits 15:8 on lane bits 7:0. The read result is {second cycle bits 7:0, first cycle bits 15:8}.
- R6: `done` is high for exactly one cycle, in the cycle after the clock edge that completes the last bus cycle. `req_ready` is 0 from acceptance until after `done`.
- R7: If `req_priv_ok`=0 when a request is accepted, no bus cycle is issued. `done` and `fault` are both 1 in the next cycle, and `rdata` is 0.
- R8: `rsvd_hit` is 1 together with `done` when any port the access touches lies in 0x00F8..0x00FF, including the second port of a word. Otherwise it is 0. The access still runs. `fault` and `rsvd_hit` are 0 whenever `done` is 0.
- R9: While `bus_cyc` is 0, `bus_addr`, `bus_be`, `bus_wdata` and `bus_we` are all 0. `bus_we` is 1 during a cycle for an output (`req_write`=1) request.
- R10: A bus cycle lasts until `bus_ack` is 1 at a clock edge. While it waits, `bus_addr`, `bus_be` and `bus_wdata` do not change.
- R11: When a write completes, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_addr | input | 16 | Port address |
| req_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_write | input | 1 | 1 = output to port, 0 = input from port |
| req_wdata | input | 16 | Write data, right-justified |
| req_priv_ok | input | 1 | 1 = I/O allowed, 0 = refuse |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Right-justified read data, valid with done |
| fault | output | 1 | Request refused, valid with done |
| rsvd_hit | output | 1 | Reserved window touched, valid with done |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_addr | output | 16 | Bus port address |
| bus_be | output | 2 | Lane enables, bit 0 = bits 7:0 |
| bus_we | output | 1 | Bus cycle is a write |
| bus_wdata | output | 16 | Lane-aligned write data |
| bus_rdata | input | 16 | Lane-aligned read data |
| bus_ack | input | 1 | Completes the current bus cycle |

## Verification
The split sequencer is the main risk. If it is stuck in or skips its second phase, the result shows up at once as a wrong number of `bus_cyc` periods and a `done` that comes one cycle early or late. A lost or swapped captured byte shows only in `rdata` at the `done` pulse, so every read is compared against a port model that gives each address a distinct byte. A stale flag or a wrong lane select shows in the enables and data of the very first bus cycle. The bench also checks the bus lines while the bus is quiet, so leftover drive is caught in the cycle where `done` is seen.

// File: rtl/io_steer_pkg.sv
package io_steer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC1 = 2'd1,
    ST_CYC2 = 2'd2,
    ST_RESP = 2'd3
  } io_state_e;
endpackage

// File: rtl/io_rsvd_decode.sv
module io_rsvd_decode #(
  parameter int          AW      = 16,
  parameter logic [AW-1:0] WIN_LO = 'h00F8,
  parameter logic [AW-1:0] WIN_HI = 'h00FF
) (
  input  logic [AW-1:0] addr,
  input  logic          word,
  output logic          hit
);
  logic [AW-1:0] addr_nxt;
  logic          hit_lo, hit_hi;

  always_comb begin
    addr_nxt = addr + 1'b1;
    hit_lo   = (addr >= WIN_LO) && (addr <= WIN_HI);
    hit_hi   = word && (addr_nxt >= WIN_LO) && (addr_nxt <= WIN_HI);
    hit      = hit_lo || hit_hi;
  end
endmodule

// File: rtl/io_lane_map.sv
module io_lane_map #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          active,
  input  logic          second,
  input  logic [AW-1:0] addr,
  input  logic          word,
  input  logic          write,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_be,
  output logic [DW-1:0] bus_wdata
);
  localparam int BW = DW / 2;

  logic          full;
  logic [BW-1:0] one_byte;

  always_comb begin
    full     = word && !addr[0];
    one_byte = second ? wdata[DW-1:BW] : wdata[BW-1:0];
    if (!active)      bus_be = 2'b00;
    else if (full)    bus_be = 2'b11;
    else if (second)  bus_be = 2'b01;
    else              bus_be = addr[0] ? 2'b10 : 2'b01;
    if (!active)      bus_addr = '0;
    else if (second)  bus_addr = addr + 1'b1;
    else              bus_addr = addr;
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    always_comb begin
      if (!bus_be[l] || !write) bus_wdata[l*BW +: BW] = '0;
      else if (full)            bus_wdata[l*BW +: BW] = wdata[l*BW +: BW];
      else                      bus_wdata[l*BW +: BW] = one_byte;
    end
  end
endmodule

// File: rtl/io_read_merge.sv
module io_read_merge #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap,
  input  logic          second,
  input  logic          full,
  input  logic          odd,
  input  logic [DW-1:0] rd_in,
  output logic [DW-1:0] rd_out
);
  localparam int BW = DW / 2;

  logic [DW-1:0] rd_q, rd_d;
  logic          rd_en;

  always_comb begin
    rd_en = clr || cap;
    rd_d  = rd_q;
    if (clr) begin
      rd_d = '0;
    end else if (cap) begin
      if (full)        rd_d = rd_in;
      else if (second) rd_d[DW-1:BW] = rd_in[BW-1:0];
      else             rd_d[BW-1:0] = odd ? rd_in[DW-1:BW] : rd_in[BW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_out = rd_q;
endmodule

// File: rtl/io_lane_steer.sv
module io_lane_steer
  import io_steer_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            DW      = 16,
  parameter logic [AW-1:0] RSVD_LO = 'h00F8,
  parameter logic [AW-1:0] RSVD_HI = 'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_priv_ok,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          fault,
  output logic          rsvd_hit,
  output logic          bus_cyc,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_be,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack
);
  logic [1:0]    rst_sync_q;
  logic          run;
  io_state_e     st_q, st_d;
  logic [AW-1:0] addr_q;
  logic          word_q, write_q, fault_q, rsvd_q;
  logic [DW-1:0] wdata_q;
  logic          accept, second, split, cap, rsvd_c;
  logic [DW-1:0] rd_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];

  assign req_ready = run && (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign bus_cyc   = (st_q == ST_CYC1) || (st_q == ST_CYC2);
  assign second    = (st_q == ST_CYC2);
  assign split     = word_q && addr_q[0];
  assign bus_we    = bus_cyc && write_q;
  assign cap       = bus_cyc && bus_ack && !write_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept)  st_d = req_priv_ok ? ST_CYC1 : ST_RESP;
      ST_CYC1: if (bus_ack) st_d = split ? ST_CYC2 : ST_RESP;
      ST_CYC2: if (bus_ack) st_d = ST_RESP;
      ST_RESP:              st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= ST_IDLE;
    else if (run) st_q <= st_d;
    else          st_q <= ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
      fault_q <= 1'b0;
      rsvd_q  <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      word_q  <= req_word;
      write_q <= req_write;
      wdata_q <= req_wdata;
      fault_q <= !req_priv_ok;
      rsvd_q  <= rsvd_c;
    end
  end

  io_rsvd_decode #(.AW(AW), .WIN_LO(RSVD_LO), .WIN_HI(RSVD_HI)) u_rsvd (
    .addr (req_addr),
    .word (req_word),
    .hit  (rsvd_c)
  );

  io_lane_map #(.AW(AW), .DW(DW)) u_map (
    .active    (bus_cyc),
    .second    (second),
    .addr      (addr_q),
    .word      (word_q),
    .write     (write_q),
    .wdata     (wdata_q),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata)
  );

  io_read_merge #(.DW(DW)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .cap    (cap),
    .second (second),
    .full   (word_q && !addr_q[0]),
    .odd    (addr_q[0]),
    .rd_in  (bus_rdata),
    .rd_out (rd_q)
  );

  assign done     = (st_q == ST_RESP);
  assign fault    = done && fault_q;
  assign rsvd_hit = done && rsvd_q;
  assign rdata    = done ? rd_q : '0;
endmodule

// File: rtl/io_steer_chk.sv
module io_steer_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_priv_ok,
  input logic          done,
  input logic          fault,
  input logic          rsvd_hit,
  input logic          bus_cyc,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_be,
  input logic          bus_we,
  input logic [DW-1:0] bus_wdata
);
  p_word_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_be == 2'b11) |-> !bus_addr[0]);

  p_split_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_cyc) && $past(bus_ack) && bus_cyc) |->
      (bus_be == 2'b01 && bus_addr == $past(bus_addr) + 1'b1));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc || done) |-> !req_ready);

  p_priv_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_priv_ok) |=> (!bus_cyc && done && fault));

  p_flags_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!fault && !rsvd_hit));

  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> (bus_be == 2'b00 && !bus_we && bus_wdata == '0 && bus_addr == '0));

  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ack) |=>
      (bus_cyc && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata)));
endmodule

bind io_lane_steer io_steer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_priv_ok (req_priv_ok),
  .done        (done),
  .fault       (fault),
  .rsvd_hit    (rsvd_hit),
  .bus_cyc     (bus_cyc),
  .bus_ack     (bus_ack),
  .bus_addr    (bus_addr),
  .bus_be      (bus_be),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata)
);

// File: tb/tb_io_lane_steer.sv
module tb_io_lane_steer;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_word, req_write, req_priv_ok;
  logic [15:0] req_addr, req_wdata;
  logic        done, fault, rsvd_hit;
  logic [15:0] rdata;
  logic        bus_cyc, bus_we, bus_ack;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_be;

  int vectors = 0;
  int errors  = 0;

  logic [15:0] b_addr [2];
  logic [1:0]  b_be   [2];
  logic [15:0] b_wd   [2];
  logic        b_we   [2];
  int          n_beats, lat;
  logic [15:0] r_rdata;
  logic        r_fault, r_rsvd;

  io_lane_steer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_wdata(req_wdata), .req_priv_ok(req_priv_ok), .done(done),
    .rdata(rdata), .fault(fault), .rsvd_hit(rsvd_hit), .bus_cyc(bus_cyc),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] pb(input logic [15:0] a);
    return a[7:0] ^ 8'hA5 ^ {a[11:8], a[15:12]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request, bus responder with `waits` wait cycles per bus cycle
  task automatic run_access(input logic [15:0] a, input logic w, input logic wr,
                            input logic [15:0] wd, input logic pok, input int waits);
    int wc;
    logic [15:0] ba;
    n_beats = 0; lat = 0; wc = 0;
    @(negedge clk);
    req_addr = a; req_word = w; req_write = wr; req_wdata = wd;
    req_priv_ok = pok; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      lat++;
      if (done) begin
        r_rdata = rdata; r_fault = fault; r_rsvd = rsvd_hit;
        chk("R9 quiet bus", {bus_addr, bus_wdata}, 32'h0);
        chk("R9 quiet be/we", {bus_be, bus_we}, 32'h0);
        req_valid = 1'b0; bus_ack = 1'b0;
        break;
      end
      if (bus_cyc) begin
        if (wc < waits) begin
          bus_ack = 1'b0; wc++;
        end else begin
          if (n_beats < 2) begin
            b_addr[n_beats] = bus_addr; b_be[n_beats] = bus_be;
            b_wd[n_beats] = bus_wdata;  b_we[n_beats] = bus_we;
          end
          ba = bus_addr;
          bus_rdata = {pb({ba[15:1], 1'b1}), pb({ba[15:1], 1'b0})};
          bus_ack = 1'b1; wc = 0; n_beats++;
        end
      end else begin
        bus_ack = 1'b0;
      end
    end
  endtask

  task automatic t_reset;
    chk("R1 ready", req_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 bus_cyc", bus_cyc, 0);
  endtask

  task automatic t_byte_even;
    run_access(16'h1234, 0, 1, 16'hBEEF, 1, 0);
    chk("R2 beats", n_beats, 1);
    chk("R2 addr", b_addr[0], 16'h1234);
    chk("R2 be", b_be[0], 2'b01);
    chk("R2 wdata", b_wd[0], 16'h00EF);
    chk("R9 we", b_we[0], 1);
    chk("R11 rdata on write", r_rdata, 0);
    run_access(16'h1234, 0, 0, 16'h0000, 1, 0);
    chk("R2 read", r_rdata, {8'h00, pb(16'h1234)});
    chk("R9 read we", b_we[0], 0);
  endtask

  task automatic t_byte_odd;
    run_access(16'h3457, 0, 1, 16'hBEEF, 1, 0);
    chk("R3 beats", n_beats, 1);
    chk("R3 addr", b_addr[0], 16'h3457);
    chk("R3 be", b_be[0], 2'b10);
    chk("R3 wdata", b_wd[0], 16'hEF00);
    run_access(16'h3457, 0, 0, 16'h0000, 1, 0);
    chk("R3 read", r_rdata, {8'h00, pb(16'h3457)});
  endtask

  task automatic t_word_even;
    run_access(16'h2000, 1, 1, 16'hCAFE, 1, 0);
    chk("R4 beats", n_beats, 1);
    chk("R4 be", b_be[0], 2'b11);
    chk("R4 wdata", b_wd[0], 16'hCAFE);
    chk("R6 latency", lat, 2);
    run_access(16'h2000, 1, 0, 16'h0000, 1, 0);
    chk("R4 read", r_rdata, {pb(16'h2001), pb(16'h2000)});
  endtask

  task automatic t_word_odd;
    run_access(16'h4001, 1, 1, 16'h1357, 1, 0);
    chk("R5 beats", n_beats, 2);
    chk("R5 addr0", b_addr[0], 16'h4001);
    chk("R5 be0", b_be[0], 2'b10);
    chk("R5 wd0", b_wd[0], 16'h5700);
    chk("R5 addr1", b_addr[1], 16'h4002);
    chk("R5 be1", b_be[1], 2'b01);
    chk("R5 wd1", b_wd[1], 16'h0013);
    chk("R6 split latency", lat, 3);
    run_access(16'h4001, 1, 0, 16'h0000, 1, 0);
    chk("R5 read", r_rdata, {pb(16'h4002), pb(16'h4001)});
    run_access(16'hFFFF, 1, 0, 16'h0000, 1, 0);
    chk("R5 wrap addr1", b_addr[1], 16'h0000);
    chk("R5 wrap read", r_rdata, {pb(16'h0000), pb(16'hFFFF)});
  endtask

  task automatic t_priv;
    run_access(16'h0060, 1, 1, 16'h5555, 0, 0);
    chk("R7 no bus", n_beats, 0);
    chk("R7 fault", r_fault, 1);
    chk("R7 latency", lat, 1);
    chk("R7 rdata", r_rdata, 0);
    run_access(16'h0060, 0, 0, 16'h0000, 1, 0);
    chk("R7 allowed no fault", r_fault, 0);
    chk("R7 allowed runs", n_beats, 1);
  endtask

  task automatic t_rsvd;
    run_access(16'h00F8, 0, 0, 16'h0, 1, 0); chk("R8 F8", r_rsvd, 1);
    chk("R8 still runs", n_beats, 1);
    run_access(16'h00FF, 0, 1, 16'h0, 1, 0); chk("R8 FF", r_rsvd, 1);
    run_access(16'h00F7, 0, 0, 16'h0, 1, 0); chk("R8 F7 byte", r_rsvd, 0);
    run_access(16'h00F7, 1, 0, 16'h0, 1, 0); chk("R8 F7 word", r_rsvd, 1);
    run_access(16'h0100, 0, 0, 16'h0, 1, 0); chk("R8 100", r_rsvd, 0);
    run_access(16'h00FE, 1, 1, 16'h0, 1, 0); chk("R8 FE word", r_rsvd, 1);
  endtask

  task automatic t_wait;
    run_access(16'h6A03, 1, 0, 16'h0000, 1, 3);
    chk("R10 latency", lat, 9);
    chk("R10 beats", n_beats, 2);
    chk("R10 read", r_rdata, {pb(16'h6A04), pb(16'h6A03)});
    run_access(16'h0802, 1, 1, 16'hA1B2, 1, 2);
    chk("R10 write latency", lat, 4);
    chk("R10 write data", b_wd[0], 16'hA1B2);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_word = 1'b0;
    req_write = 1'b0; req_wdata = '0; req_priv_ok = 1'b1;
    bus_ack = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_byte_even;
    t_byte_odd;
    t_word_even;
    t_word_odd;
    t_priv;
    t_rsvd;
    t_wait;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule